// File: doc/BRIEF.md
# Opcode-Match Instruction Throttle

This block sits beside an instruction decoder. It slows down one chosen instruction by stalling it, and every other instruction goes through untouched. It checks the first opcode byte of each instruction that arrives at decode against a programmed match byte. The comparison can ignore selected bits. On a hit, the block raises a stall request for a programmable number of cycles and keeps the decode-valid signal low during that time. After the stall it lets that instruction through once. A separate legacy slow bit applies a fixed four-cycle slowdown to the loop opcode E2h, whatever the match registers hold.

The configuration registers sit behind an access key. The key register is always readable and writable. Only the key value 0001b opens the other registers. While they are closed, writes to them are dropped and reads of them return zero. Writing 00h to the match register and to all control bytes turns off programmed throttling.

Top module: `opcode_throttle`

## Requirements
- R1: After reset, every configuration register reads 00h, the block is locked, and `stall_req` is low.
- R2: Address 0 holds the 4-bit key in bits 3:0. It is always writable and always readable, with the upper bits reading 0. Key 0001b unlocks the block and any other value locks it.
- R3: While locked, writes to addresses 1 to 5 are ignored and reads from them return 00h.
- R4: While unlocked, the registers read back as written: address 1 is the match byte, address 2 is control A, address 3 is control B (the ignore mask), and address 4 is control C (storage only). Address 5 keeps only bit 0, the legacy slow bit. Addresses 6 and 7 read 00h.
- R5: Control A bit 7 enables matching and control A bits 3:0 give the count. The mask ignores opcode bits where control B has a 1. When a valid opcode matches, `stall_req` rises in the same cycle and stays high for L cycles, where L is the count with a floor of 4. The instruction is then passed once.
- R6: If the enable bit is 0 or the count is 0, a matching opcode passes in the cycle it arrives, with no stall.
- R7: When the slow bit is set, opcode E2h stalls for 4 cycles. If the programmed match also hits, the programmed length applies instead.
- R8: Each new instance of a matching instruction is throttled again, including one that follows straight after the previous one.
- R9: Opcodes that do not match pass in the cycle they arrive.
- R10: `dec_valid_out` equals `dec_valid_in` while `stall_req` is low, and is 0 while `stall_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| dec_valid_in | input | 1 | Instruction present at decode; held while stalled |
| dec_opcode | input | 8 | First opcode byte of that instruction |
| dec_valid_out | output | 1 | Gated valid passed on to decode |
| stall_req | output | 1 | Serialize/stall request; the source must hold the instruction |

## Verification
A stuck key or a corrupted register shows up on the next read at `cfg_rdata`, which is combinational and so shows it in the same cycle. A wrong stall count or a lost pass flag changes how many cycles `stall_req` stays high for an instruction. The bench counts those cycles exactly for lengths below, at and above the floor. A pass flag that is never cleared would let the next identical instruction go through without a stall. Back-to-back instances catch this within one instruction.

// File: rtl/opcode_throttle.sv
module opcode_throttle #(
  parameter logic [7:0] LEGACY_OP  = 8'hE2,
  parameter logic [3:0] UNLOCK_KEY = 4'b0001,
  parameter int         MIN_STALL  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [2:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       dec_valid_in,
  input  logic [7:0] dec_opcode,
  output logic       dec_valid_out,
  output logic       stall_req
);
  localparam logic [3:0] MIN_LEN = 4'(MIN_STALL);

  logic [3:0] key_q, cnt_q;
  logic [7:0] match_q, ctl_a_q, ctl_b_q, ctl_c_q;
  logic       slow_q, pass_q;

  wire unlocked = (key_q == UNLOCK_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q   <= '0;
      match_q <= '0;
      ctl_a_q <= '0;
      ctl_b_q <= '0;
      ctl_c_q <= '0;
      slow_q  <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_addr == 3'd0) key_q <= cfg_wdata[3:0];
      else if (unlocked) begin
        case (cfg_addr)
          3'd1:    match_q <= cfg_wdata;
          3'd2:    ctl_a_q <= cfg_wdata;
          3'd3:    ctl_b_q <= cfg_wdata;
          3'd4:    ctl_c_q <= cfg_wdata;
          3'd5:    slow_q  <= cfg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == 3'd0) cfg_rdata = {4'b0, key_q};
    else if (unlocked) begin
      case (cfg_addr)
        3'd1:    cfg_rdata = match_q;
        3'd2:    cfg_rdata = ctl_a_q;
        3'd3:    cfg_rdata = ctl_b_q;
        3'd4:    cfg_rdata = ctl_c_q;
        3'd5:    cfg_rdata = {7'b0, slow_q};
        default: cfg_rdata = '0;
      endcase
    end
  end

  wire [3:0] prog_len = (ctl_a_q[3:0] < MIN_LEN) ? MIN_LEN : ctl_a_q[3:0];
  wire prog_hit = ctl_a_q[7] && (ctl_a_q[3:0] != 4'd0) &&
                  (((dec_opcode ^ match_q) & ~ctl_b_q) == 8'h00);
  wire slow_hit = slow_q && (dec_opcode == LEGACY_OP);
  wire busy     = (cnt_q != 4'd0);
  wire start    = dec_valid_in && (prog_hit || slow_hit) && !pass_q && !busy;
  wire [3:0] len = prog_hit ? prog_len : MIN_LEN;

  assign stall_req     = start | busy;
  assign dec_valid_out = dec_valid_in & ~stall_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pass_q <= 1'b0;
    end else begin
      if (start)     cnt_q <= len - 4'd1;
      else if (busy) cnt_q <= cnt_q - 4'd1;
      if (busy && cnt_q == 4'd1)       pass_q <= 1'b1;
      else if (dec_valid_in && pass_q) pass_q <= 1'b0;
    end
  end

  // R10
  valid_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall_req && dec_valid_out));

  // R3
  locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && cfg_addr != 3'd0) |-> cfg_rdata == 8'h00);

  // R3
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr != 3'd0 && !unlocked) |=>
      ($stable(match_q) && $stable(ctl_a_q) && $stable(ctl_b_q) && $stable(ctl_c_q) && $stable(slow_q)));

  // R5
  min_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_req) |=> stall_req);

  // R5
  pass_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_q |-> !stall_req);

  // R1
  reset_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(cfg_we && cfg_addr == 3'd0));
endmodule

// File: tb/tb_opcode_throttle.sv
module tb_opcode_throttle;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic dec_valid_in = 1'b0;
  logic [7:0] dec_opcode = '0;
  logic dec_valid_out, stall_req;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  opcode_throttle dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #2 chk(req, cfg_rdata, exp);
  endtask

  task automatic issue(input string req, input logic [7:0] op, input int exp_stall);
    int n = 0;
    bit bad = 0;
    @(negedge clk);
    dec_valid_in = 1'b1; dec_opcode = op;
    for (int i = 0; i < 40; i++) begin
      #2;
      if (stall_req == dec_valid_out) bad = 1;
      if (dec_valid_out) break;
      n++;
      @(negedge clk);
    end
    chk(req, n, exp_stall);
    chk("R10 valid gating", bad, 0);
    @(negedge clk);
    dec_valid_in = 1'b0;
  endtask

  task automatic t_reset();
    for (int a = 0; a < 6; a++) rd("R1 reset value", 3'(a), 8'h00);
    chk("R1 no stall at reset", stall_req, 0);
  endtask

  task automatic t_lock();
    wr(3'd1, 8'hE2);
    rd("R3 locked read", 3'd1, 8'h00);
    wr(3'd0, 8'hF1);
    rd("R2 key read upper bits zero", 3'd0, 8'h01);
    rd("R3 locked write ignored", 3'd1, 8'h00);
    wr(3'd0, 8'h05);
    rd("R2 key read", 3'd0, 8'h05);
    rd("R2 other key locks", 3'd2, 8'h00);
    wr(3'd0, 8'h01);
  endtask

  task automatic t_regs();
    wr(3'd1, 8'hA5); wr(3'd2, 8'h3C); wr(3'd3, 8'h0F); wr(3'd4, 8'h99); wr(3'd5, 8'hFF);
    rd("R4 match", 3'd1, 8'hA5);
    rd("R4 ctl a", 3'd2, 8'h3C);
    rd("R4 ctl b", 3'd3, 8'h0F);
    rd("R4 ctl c", 3'd4, 8'h99);
    rd("R4 slow bit only", 3'd5, 8'h01);
    rd("R4 addr 6", 3'd6, 8'h00);
    rd("R4 addr 7", 3'd7, 8'h00);
    wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
  endtask

  task automatic t_disabled();
    wr(3'd1, 8'hE2);
    issue("R6 all clear", 8'hE2, 0);
    wr(3'd2, 8'h80);
    issue("R6 count zero", 8'hE2, 0);
    wr(3'd2, 8'h07);
    issue("R6 enable clear", 8'hE2, 0);
  endtask

  task automatic t_prog();
    wr(3'd2, 8'h82);
    issue("R5 floor of 4", 8'hE2, 4);
    wr(3'd2, 8'h87);
    issue("R5 count 7", 8'hE2, 7);
    issue("R9 nonmatching", 8'h10, 0);
    issue("R8 first instance", 8'hE2, 7);
    issue("R8 second instance", 8'hE2, 7);
  endtask

  task automatic t_mask();
    wr(3'd3, 8'h0F);
    issue("R5 masked bits ignored", 8'hE5, 7);
    issue("R9 unmasked mismatch", 8'hF2, 0);
    wr(3'd3, 8'h00);
  endtask

  task automatic t_legacy();
    wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd5, 8'h01);
    issue("R7 slow bit", 8'hE2, 4);
    issue("R7 slow other opcode", 8'hE3, 0);
    wr(3'd1, 8'hE2); wr(3'd2, 8'h89);
    issue("R7 programmed wins", 8'hE2, 9);
  endtask

  task automatic t_locked_run();
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h00);
    issue("R3 locked write keeps throttle", 8'hE2, 9);
    wr(3'd0, 8'h01);
    rd("R3 value survived lock", 3'd2, 8'h89);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_lock();
        t_regs();
        t_disabled();
        t_prog();
        t_mask();
        t_legacy();
        t_locked_run();
      end
      begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule